// File: doc/BRIEF.md
# Region-Aware Console I/O Port Decoder

This block sits between an 8-bit CPU's I/O cycles and the peripherals of a small console. On every IN or OUT cycle it looks at bits 7, 6 and 0 of the 8-bit port number to pick a peripheral group: the controller interface, the sound generator (PSG), the video data and status ports, or a high group that holds an optional FM synthesiser. It raises a single-cycle strobe towards the chosen target and, for reads, returns the byte on `rd_data` in the same cycle.

A region input switches between two decode styles. With `region_jp` low, the controller and FM windows are partially decoded, so every mirror of a window responds. With `region_jp` high, only exact port numbers respond. The full-decode mode also holds a 2-bit audio mix register that decides whether the PSG, the FM chip, both or neither feed the audio output. Bit 2 of a memory-control byte supplied from outside can switch off controller reads. In partial-decode mode, high-group reads combine the FM byte and the controller byte with a bitwise AND.

Top module: `iop_decode`

## Requirements
- R1: A write with `port_addr & 0xC1` equal to 0x40 or 0x41 pulses `psg_wr`. When it equals 0x80 it pulses `vdp_data_wr`, and when it equals 0x81 it pulses `vdp_ctrl_wr`. Region makes no difference.
- R2: A read with `port_addr & 0xC1` equal to 0x40 pulses `hv_rd` and returns `hv_count[15:8]`. Equal to 0x41, it pulses `hv_rd` and returns `hv_count[7:0]`. Equal to 0x80, it pulses `vdp_data_rd` and returns `vdp_rdata`. Equal to 0x81, it pulses `vdp_stat_rd` and returns `vdp_status`.
- R3: A write with `port_addr & 0xC1` in {0x00, 0x01} pulses `ctl_wr` for every such port when `region_jp`=0. When `region_jp`=1 it pulses `ctl_wr` only for 0x3E and 0x3F.
- R4: When `region_jp`=1 and `fm_present`=1, writes to 0xF0 and 0xF1 pulse `fm_wr`, and a write to 0xF2 loads `wr_data[1:0]` into the audio register without pulsing `fm_wr`. When `fm_present`=0, none of these writes has any effect. No other high-group port responds to a write in this region.
- R5: The audio register resets to 00. `psg_en` is 1 for the codes 00 and 11. `fm_en` is 1 for the codes 01 and 11. Code 10 mutes both.
- R6: When `region_jp`=1, a read of 0xF2 returns 0 in bits 7..2 and the audio register in bits 1..0, whatever the value of `fm_present`.
- R7: When `region_jp`=1, a read of 0xC0, 0xC1, 0xDC or 0xDD with `mem_ctrl[2]`=0 pulses `ctl_rd` and returns `ctl_rdata`. Any other high-group read in this region, including those four ports while `mem_ctrl[2]`=1, returns 0xFF with no strobe.
- R8: When `region_jp`=0, a read with `port_addr & 0xC1` in {0xC0, 0xC1} starts from 0xFF. If `port_addr[2]`=0 and `fm_present`=1, it pulses `fm_rd` and ANDs in `fm_rdata`. If `mem_ctrl[2]`=0, it pulses `ctl_rd` and ANDs in `ctl_rdata`.
- R9: When `region_jp`=0, a high-group write pulses `fm_wr` exactly when `port_addr[2]`=0 and `fm_present`=1. The audio register is never loaded in this region.
- R10: Reads with `port_addr & 0xC1` in {0x00, 0x01} return 0xFF with no strobe. With `rd_stb` low, `rd_data` is 0xFF. With both `rd_stb` and `wr_stb` low, every strobe is 0.
- R11: At most one write target (controller, PSG, video data, video control, FM, audio register) is selected in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_jp | input | 1 | 1 = full address decode, 0 = partial decode |
| fm_present | input | 1 | FM synthesiser fitted and enabled |
| mem_ctrl | input | 8 | Memory-control byte; bit 2 set disables controller reads |
| port_addr | input | 8 | Port number of the current I/O cycle |
| wr_stb | input | 1 | OUT cycle strobe (exclusive with rd_stb) |
| rd_stb | input | 1 | IN cycle strobe |
| wr_data | input | 8 | OUT cycle data |
| rd_data | output | 8 | IN cycle return data |
| ctl_wr | output | 1 | Controller interface write |
| ctl_rd | output | 1 | Controller interface read |
| psg_wr | output | 1 | PSG write |
| vdp_data_wr | output | 1 | Video data port write |
| vdp_ctrl_wr | output | 1 | Video control port write |
| vdp_data_rd | output | 1 | Video data port read |
| vdp_stat_rd | output | 1 | Video status read |
| hv_rd | output | 1 | Beam counter read |
| fm_wr | output | 1 | FM chip write |
| fm_rd | output | 1 | FM chip read |
| ctl_rdata | input | 8 | Controller read data |
| hv_count | input | 16 | Beam counter, vertical in the high byte |
| vdp_rdata | input | 8 | Video data port read data |
| vdp_status | input | 8 | Video status byte |
| fm_rdata | input | 8 | FM chip read data |
| psg_en | output | 1 | PSG audio enabled |
| fm_en | output | 1 | FM audio enabled |

## Verification
The bound checker watches every cycle for these properties: write targets stay exclusive, `fm_wr` never appears without an FM chip, full decode never sends a controller write outside 0x3E/0x3F, a disabled controller is never read in full-decode mode, and the enable outputs change only through a load of the audio register and then follow the loaded code. What the checker cannot express is the value on the read path. The AND of FM and controller bytes, the beam counter byte order, the 0xFF default and the read-back of the mix register are shown only by the bench. It walks a table of port/region/enable combinations and then runs directed audio-register sequences and a reset in the middle of a run.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    GRP_CTL  = 2'b00,
    GRP_SND  = 2'b01,
    GRP_VID  = 2'b10,
    GRP_HIGH = 2'b11
  } grp_e;

  localparam logic [ADDR_W-1:0] P_FM_ADDR = 8'hF0;
  localparam logic [ADDR_W-1:0] P_FM_DATA = 8'hF1;
  localparam logic [ADDR_W-1:0] P_AUDIO   = 8'hF2;
  localparam logic [ADDR_W-2:0] P_CTL_JP  = 7'h1F;

  // group is carried by bits 7..6 once the address is masked with 0xC1
  function automatic grp_e port_group(input logic [ADDR_W-1:0] a);
    return grp_e'(a[7:6]);
  endfunction

  function automatic logic ctl_mirror(input logic [ADDR_W-1:0] a);
    return (a == 8'hC0) || (a == 8'hC1) || (a == 8'hDC) || (a == 8'hDD);
  endfunction

  function automatic logic mix_psg(input logic [1:0] code);
    return (code == 2'b00) || (code == 2'b11);
  endfunction

  function automatic logic mix_fm(input logic [1:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/iop_classify.sv
module iop_classify
  import iop_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic              sub
);
  assign grp = port_group(addr);
  assign sub = addr[0];
endmodule

// File: rtl/iop_wr_steer.sv
module iop_wr_steer
  import iop_pkg::*;
(
  input  logic              wr_stb,
  input  grp_e              grp,
  input  logic              sub,
  input  logic [ADDR_W-1:0] addr,
  input  logic              region_jp,
  input  logic              fm_present,
  output logic              ctl_wr,
  output logic              psg_wr,
  output logic              vdd_wr,
  output logic              vdc_wr,
  output logic              fm_wr,
  output logic              aud_load
);
  always_comb begin
    ctl_wr   = 1'b0;
    psg_wr   = 1'b0;
    vdd_wr   = 1'b0;
    vdc_wr   = 1'b0;
    fm_wr    = 1'b0;
    aud_load = 1'b0;
    if (wr_stb) begin
      unique case (grp)
        GRP_CTL: ctl_wr = !region_jp || (addr[ADDR_W-1:1] == P_CTL_JP);
        GRP_SND: psg_wr = 1'b1;
        GRP_VID: begin
          vdd_wr = !sub;
          vdc_wr = sub;
        end
        GRP_HIGH: begin
          if (region_jp) begin
            if (fm_present) begin
              fm_wr    = (addr == P_FM_ADDR) || (addr == P_FM_DATA);
              aud_load = (addr == P_AUDIO);
            end
          end else begin
            fm_wr = !addr[2] && fm_present;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iop_rd_steer.sv
module iop_rd_steer
  import iop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              rd_stb,
  input  grp_e              grp,
  input  logic              sub,
  input  logic [ADDR_W-1:0] addr,
  input  logic              region_jp,
  input  logic              fm_present,
  input  logic              io_off,
  input  logic [1:0]        aud_code,
  input  logic [DW-1:0]     ctl_rdata,
  input  logic [2*DW-1:0]   hv_count,
  input  logic [DW-1:0]     vdp_rdata,
  input  logic [DW-1:0]     vdp_status,
  input  logic [DW-1:0]     fm_rdata,
  output logic              ctl_rd,
  output logic              hv_rd,
  output logic              vdd_rd,
  output logic              vds_rd,
  output logic              fm_rd,
  output logic [DW-1:0]     rd_data
);
  always_comb begin
    ctl_rd  = 1'b0;
    hv_rd   = 1'b0;
    vdd_rd  = 1'b0;
    vds_rd  = 1'b0;
    fm_rd   = 1'b0;
    rd_data = '1;
    if (rd_stb) begin
      unique case (grp)
        GRP_CTL: ;
        GRP_SND: begin
          hv_rd   = 1'b1;
          rd_data = sub ? hv_count[DW-1:0] : hv_count[2*DW-1:DW];
        end
        GRP_VID: begin
          vdd_rd  = !sub;
          vds_rd  = sub;
          rd_data = sub ? vdp_status : vdp_rdata;
        end
        GRP_HIGH: begin
          if (region_jp) begin
            if (addr == P_AUDIO) begin
              rd_data      = '0;
              rd_data[1:0] = aud_code;
            end else if (ctl_mirror(addr) && !io_off) begin
              ctl_rd  = 1'b1;
              rd_data = ctl_rdata;
            end
          end else begin
            if (!addr[2] && fm_present) begin
              fm_rd   = 1'b1;
              rd_data = rd_data & fm_rdata;
            end
            if (!io_off) begin
              ctl_rd  = 1'b1;
              rd_data = rd_data & ctl_rdata;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iop_audio_reg.sv
module iop_audio_reg
  import iop_pkg::*;
#(
  parameter logic [1:0] RESET_CODE = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] din,
  output logic [1:0] code,
  output logic       psg_en,
  output logic       fm_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code <= RESET_CODE;
    else if (load) code <= din;
  end

  assign psg_en = mix_psg(code);
  assign fm_en  = mix_fm(code);
endmodule

// File: rtl/iop_decode.sv
module iop_decode
  import iop_pkg::*;
#(
  parameter int DW         = 8,
  parameter int IO_OFF_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              region_jp,
  input  logic              fm_present,
  input  logic [DW-1:0]     mem_ctrl,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              ctl_wr,
  output logic              ctl_rd,
  output logic              psg_wr,
  output logic              vdp_data_wr,
  output logic              vdp_ctrl_wr,
  output logic              vdp_data_rd,
  output logic              vdp_stat_rd,
  output logic              hv_rd,
  output logic              fm_wr,
  output logic              fm_rd,
  input  logic [DW-1:0]     ctl_rdata,
  input  logic [2*DW-1:0]   hv_count,
  input  logic [DW-1:0]     vdp_rdata,
  input  logic [DW-1:0]     vdp_status,
  input  logic [DW-1:0]     fm_rdata,
  output logic              psg_en,
  output logic              fm_en
);
  grp_e       grp;
  logic       sub;
  logic       aud_load;
  logic [1:0] aud_code;
  logic       io_off;

  assign io_off = mem_ctrl[IO_OFF_BIT];

  iop_classify u_cls (
    .addr (port_addr),
    .grp  (grp),
    .sub  (sub)
  );

  iop_wr_steer u_wr (
    .wr_stb     (wr_stb),
    .grp        (grp),
    .sub        (sub),
    .addr       (port_addr),
    .region_jp  (region_jp),
    .fm_present (fm_present),
    .ctl_wr     (ctl_wr),
    .psg_wr     (psg_wr),
    .vdd_wr     (vdp_data_wr),
    .vdc_wr     (vdp_ctrl_wr),
    .fm_wr      (fm_wr),
    .aud_load   (aud_load)
  );

  iop_rd_steer #(.DW(DW)) u_rd (
    .rd_stb     (rd_stb),
    .grp        (grp),
    .sub        (sub),
    .addr       (port_addr),
    .region_jp  (region_jp),
    .fm_present (fm_present),
    .io_off     (io_off),
    .aud_code   (aud_code),
    .ctl_rdata  (ctl_rdata),
    .hv_count   (hv_count),
    .vdp_rdata  (vdp_rdata),
    .vdp_status (vdp_status),
    .fm_rdata   (fm_rdata),
    .ctl_rd     (ctl_rd),
    .hv_rd      (hv_rd),
    .vdd_rd     (vdp_data_rd),
    .vds_rd     (vdp_stat_rd),
    .fm_rd      (fm_rd),
    .rd_data    (rd_data)
  );

  iop_audio_reg u_aud (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (aud_load),
    .din    (wr_data[1:0]),
    .code   (aud_code),
    .psg_en (psg_en),
    .fm_en  (fm_en)
  );
endmodule

// File: rtl/iop_decode_chk.sv
module iop_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       region_jp,
  input logic       fm_present,
  input logic       io_off,
  input logic [7:0] port_addr,
  input logic       rd_stb,
  input logic [7:0] wr_data,
  input logic       ctl_wr,
  input logic       ctl_rd,
  input logic       psg_wr,
  input logic       vdp_data_wr,
  input logic       vdp_ctrl_wr,
  input logic       fm_wr,
  input logic       aud_load,
  input logic       psg_en,
  input logic       fm_en
);
  // R11
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_wr, psg_wr, vdp_data_wr, vdp_ctrl_wr, fm_wr, aud_load}));

  // R4
  fm_needs_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_wr || aud_load) |-> fm_present);

  // R3
  jp_ctl_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_jp && ctl_wr) |-> (port_addr[7:1] == 7'h1F));

  // R7
  jp_ctl_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_jp && rd_stb && io_off) |-> !ctl_rd);

  // R5
  mix_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aud_load |=> (fm_en == $past(wr_data[0])) &&
                 (psg_en == ($past(wr_data[1]) == $past(wr_data[0]))));

  // R9
  mix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aud_load |=> $stable({psg_en, fm_en}));
endmodule

bind iop_decode iop_decode_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .region_jp   (region_jp),
  .fm_present  (fm_present),
  .io_off      (mem_ctrl[2]),
  .port_addr   (port_addr),
  .rd_stb      (rd_stb),
  .wr_data     (wr_data),
  .ctl_wr      (ctl_wr),
  .ctl_rd      (ctl_rd),
  .psg_wr      (psg_wr),
  .vdp_data_wr (vdp_data_wr),
  .vdp_ctrl_wr (vdp_ctrl_wr),
  .fm_wr       (fm_wr),
  .aud_load    (aud_load),
  .psg_en      (psg_en),
  .fm_en       (fm_en)
);

// File: tb/sim_iop_decode.sv
module sim_iop_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic region_jp = 1'b0, fm_present = 1'b0;
  logic [7:0] mem_ctrl = 8'h00, port_addr = 8'h00, wr_data = 8'h00;
  logic wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic ctl_wr, ctl_rd, psg_wr, vdp_data_wr, vdp_ctrl_wr, vdp_data_rd;
  logic vdp_stat_rd, hv_rd, fm_wr, fm_rd, psg_en, fm_en;
  logic [7:0]  ctl_rdata = 8'hA5, vdp_rdata = 8'h96, vdp_status = 8'h1F;
  logic [7:0]  fm_rdata = 8'hF6;
  logic [15:0] hv_count = 16'h3C5A;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iop_decode u0 (
    .clk(clk), .rst_n(rst_n), .region_jp(region_jp), .fm_present(fm_present),
    .mem_ctrl(mem_ctrl), .port_addr(port_addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .rd_data(rd_data), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .psg_wr(psg_wr), .vdp_data_wr(vdp_data_wr), .vdp_ctrl_wr(vdp_ctrl_wr),
    .vdp_data_rd(vdp_data_rd), .vdp_stat_rd(vdp_stat_rd), .hv_rd(hv_rd),
    .fm_wr(fm_wr), .fm_rd(fm_rd), .ctl_rdata(ctl_rdata), .hv_count(hv_count),
    .vdp_rdata(vdp_rdata), .vdp_status(vdp_status), .fm_rdata(fm_rdata),
    .psg_en(psg_en), .fm_en(fm_en)
  );

  // {jp, fm, io_off, write} addr strobes rdata
  // strobes: ctl_wr ctl_rd psg_wr vdd_wr vdc_wr vdd_rd vds_rd hv_rd fm_wr fm_rd
  localparam int N = 31;
  localparam logic [29:0] TBL [0:N-1] = '{
    {4'b0001, 8'h7F, 10'b0010000000, 8'hFF},  // R1
    {4'b1001, 8'h40, 10'b0010000000, 8'hFF},  // R1
    {4'b0001, 8'hBE, 10'b0001000000, 8'hFF},  // R1
    {4'b0001, 8'hBF, 10'b0000100000, 8'hFF},  // R1
    {4'b0000, 8'h7E, 10'b0000000100, 8'h3C},  // R2
    {4'b0000, 8'h7F, 10'b0000000100, 8'h5A},  // R2
    {4'b0000, 8'hBE, 10'b0000010000, 8'h96},  // R2
    {4'b1000, 8'hBF, 10'b0000001000, 8'h1F},  // R2
    {4'b0001, 8'h3F, 10'b1000000000, 8'hFF},  // R3
    {4'b0001, 8'h00, 10'b1000000000, 8'hFF},  // R3
    {4'b1001, 8'h3E, 10'b1000000000, 8'hFF},  // R3
    {4'b1001, 8'h01, 10'b0000000000, 8'hFF},  // R3
    {4'b1101, 8'h3D, 10'b0000000000, 8'hFF},  // R3
    {4'b1101, 8'hF0, 10'b0000000010, 8'hFF},  // R4
    {4'b1101, 8'hF1, 10'b0000000010, 8'hFF},  // R4
    {4'b1001, 8'hF0, 10'b0000000000, 8'hFF},  // R4
    {4'b1101, 8'hF4, 10'b0000000000, 8'hFF},  // R4
    {4'b1000, 8'hDC, 10'b0100000000, 8'hA5},  // R7
    {4'b1000, 8'hC1, 10'b0100000000, 8'hA5},  // R7
    {4'b1010, 8'hDD, 10'b0000000000, 8'hFF},  // R7
    {4'b1100, 8'hF0, 10'b0000000000, 8'hFF},  // R7
    {4'b0100, 8'hF0, 10'b0100000001, 8'hA4},  // R8
    {4'b0110, 8'hF1, 10'b0000000001, 8'hF6},  // R8
    {4'b0000, 8'hDD, 10'b0100000000, 8'hA5},  // R8
    {4'b0100, 8'hC4, 10'b0100000000, 8'hA5},  // R8
    {4'b0110, 8'hC4, 10'b0000000000, 8'hFF},  // R8
    {4'b0101, 8'hC2, 10'b0000000010, 8'hFF},  // R9
    {4'b0101, 8'hF4, 10'b0000000000, 8'hFF},  // R9
    {4'b0001, 8'hF0, 10'b0000000000, 8'hFF},  // R9
    {4'b0100, 8'h3E, 10'b0000000000, 8'hFF},  // R10
    {4'b1100, 8'h00, 10'b0000000000, 8'hFF}   // R10
  };

  function automatic logic [9:0] strobes();
    return {ctl_wr, ctl_rd, psg_wr, vdp_data_wr, vdp_ctrl_wr,
            vdp_data_rd, vdp_stat_rd, hv_rd, fm_wr, fm_rd};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_stb = 1'b0;
    rd_stb = 1'b0;
  endtask

  // write one port, let the edge pass, then go idle
  task automatic do_write(input logic jp, input logic fp, input logic [7:0] a,
                          input logic [7:0] d);
    @(negedge clk);
    region_jp = jp; fm_present = fp; port_addr = a; wr_data = d;
    wr_stb = 1'b1; rd_stb = 1'b0;
    idle();
  endtask

  task automatic do_read(input logic jp, input logic [7:0] a);
    @(negedge clk);
    region_jp = jp; port_addr = a; rd_stb = 1'b1; wr_stb = 1'b0;
    #2;
  endtask

  task automatic mix_step(input logic [7:0] d, input logic exp_psg,
                          input logic exp_fm, input string req);
    do_write(1'b1, 1'b1, 8'hF2, d);
    #2;
    check(req, {psg_en, fm_en}, {exp_psg, exp_fm});
    do_read(1'b1, 8'hF2);
    check("R6", rd_data, {6'b0, d[1:0]});
    idle();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset psg", psg_en, 1'b1);
    check("R5 reset fm", fm_en, 1'b0);
    check("R10 idle strobes", strobes(), 10'b0);
    check("R10 idle rdata", rd_data, 8'hFF);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      region_jp  = TBL[i][29];
      fm_present = TBL[i][28];
      mem_ctrl   = TBL[i][27] ? 8'h04 : 8'hFB;
      wr_stb     = TBL[i][26];
      rd_stb     = !TBL[i][26];
      port_addr  = TBL[i][25:18];
      wr_data    = 8'h00;
      #2;
      check($sformatf("table %0d strobes", i), strobes(), TBL[i][17:8]);
      check($sformatf("table %0d rdata", i), rd_data, TBL[i][7:0]);
    end
    idle();
    mem_ctrl = 8'h00;
    #2;
    check("R10 idle after table", strobes(), 10'b0);

    // R5 / R6: every mix code
    mix_step(8'hFD, 1'b0, 1'b1, "R5 code01");
    mix_step(8'hFE, 1'b0, 1'b0, "R5 code10");
    mix_step(8'h03, 1'b1, 1'b1, "R5 code11");
    do_read(1'b1, 8'hF2);
    fm_present = 1'b0;
    #1;
    check("R6 no fm", rd_data, 8'h03);
    idle();

    // R9: partial decode write to F2 goes to FM, register unchanged
    @(negedge clk);
    region_jp = 1'b0; fm_present = 1'b1; port_addr = 8'hF2; wr_data = 8'h00;
    wr_stb = 1'b1;
    #2;
    check("R9 fm_wr", fm_wr, 1'b1);
    idle();
    #2;
    check("R9 mix kept", {psg_en, fm_en}, 2'b11);

    // R4: without FM chip a full-decode F2 write is ignored
    do_write(1'b1, 1'b0, 8'hF2, 8'h01);
    #2;
    check("R4 no chip mix kept", {psg_en, fm_en}, 2'b11);
    do_read(1'b1, 8'hF2);
    check("R4 no chip readback", rd_data, 8'h03);
    idle();

    // R5: reset mid-run returns to PSG only
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R5 reset again", {psg_en, fm_en}, 2'b10);
    @(negedge clk);
    rst_n = 1'b1;
    do_read(1'b1, 8'hF2);
    check("R6 after reset", rd_data, 8'h00);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule